// File: doc/BRIEF.md
# GPIO Port Register File

This block stores the configuration of eight byte-wide general-purpose I/O ports and gives the host access to it. A bus decoder upstream supplies a 4-bit register index, a write strobe, a read strobe and write data. Even indices select a port's data register and odd indices select its direction register. Index bit 0 picks the register kind, and index bits 3:1 pick the port.

A write to a data register loads the port's output latch. A read of a data register does not return that latch. It returns the pin levels, after they pass through a two-flop synchroniser. Direction registers can be written and read back.

Every pad bit has separate value and enable outputs for an external tristate buffer. The enable follows the direction bit, and the value follows the latch bit. A pin configured as an output therefore reads back its driven level through the pad.

Top module: `gpio_regfile`

## Requirements
- R1: After reset, all output latches and direction bits are 0, so every `pad_oe_o` bit and every `pad_o` bit is 0, and `rdata_o` is 0.
- R2: Index bits 3:1 select the port, which owns pad bits [8p+7:8p]. Index bit 0 selects the register kind: 0 selects the data register and 1 selects the direction register.
- R3: A write to the direction register loads `wdata_i` into it. A later read of that index returns the stored value.
- R4: A write to the data register loads `wdata_i` into that port's output latch, and `pad_o` shows the latch bits from the next cycle.
- R5: Each `pad_oe_o` bit equals its direction bit, where 1 means output and 0 means input.
- R6: A read of a data register returns the pin levels after two synchroniser flops, not the latch. A level that is stable on `pad_i` for three clock edges before the read edge is returned.
- R7: For a pin configured as an output whose pad loops back, a data read returns the driven latch value.
- R8: Read data is registered. It appears in the cycle after the edge that samples `rd_i`, and it holds while `rd_i` is low.
- R9: A write changes only the one register it selects. All other latches and direction registers keep their values.
- R10: When a read and a write to the same index fall in the same cycle, the read returns the value the register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | 4 | Register index |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pad_i | input | 64 | Pad input levels, port p in bits [8p+7:8p] |
| pad_o | output | 64 | Pad output values |
| pad_oe_o | output | 64 | Pad output enables, 1 = drive |

## Verification
The assertions assume that the decoder presents each strobe together with a valid index and data in the same cycle. They also assume that `pad_i` is sampled only through the synchroniser, so no assertion depends on the pin timing.

The pin-to-read check expects a two-edge delay and needs no settling assumption. The bench keeps to these limits by changing strobes and pad levels only at falling edges. It waits three cycles after any change that can move a pin before it issues a data read, and it models a loopback pad in which driven bits follow `pad_o`.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;
  localparam int PORTS_DEF = 8;
  localparam int WIDTH_DEF = 8;

  typedef enum logic {
    REG_DATA = 1'b0,
    REG_DIR  = 1'b1
  } reg_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  logic [1:0]   age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      age_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  assign q_o = s2_q;

  p_sync_delay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_data_i,
  input  logic         wr_dir_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] dir_o
);
  logic [W-1:0] latch_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_data_i) latch_q <= wdata_i;
      if (wr_dir_i)  dir_q   <= wdata_i;
    end
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;

  p_dir_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_i |=> (dir_o == $past(wdata_i)));
  p_latch_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> (latch_o == $past(wdata_i)));
  p_latch_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_data_i |=> $stable(latch_o));
  p_dir_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir_i |=> $stable(dir_o));
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux #(
  parameter int N     = 8,
  parameter int W     = 8,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [N-1:0][W-1:0] pin_i,
  input  logic [N-1:0][W-1:0] dir_i,
  output logic [W-1:0]      rdata_o
);
  localparam int PSEL_W = IDX_W - 1;
  logic [PSEL_W-1:0] sel;

  assign sel = idx_i[IDX_W-1:1];

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < N; p++) begin
      if (sel == PSEL_W'(p)) begin
        rdata_o = (idx_i[0] == gpio_rf_pkg::REG_DIR) ? dir_i[p] : pin_i[p];
      end
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
  parameter int NUM_PORTS = gpio_rf_pkg::PORTS_DEF,
  parameter int PORT_W    = gpio_rf_pkg::WIDTH_DEF,
  localparam int PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int IDX_W    = PSEL_W + 1,
  localparam int PAD_W    = NUM_PORTS * PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [PAD_W-1:0]  pad_i,
  output logic [PAD_W-1:0]  pad_o,
  output logic [PAD_W-1:0]  pad_oe_o
);
  logic [NUM_PORTS-1:0][PORT_W-1:0] latch_w, dir_w, pin_w;
  logic [PORT_W-1:0] rd_mux;
  logic [PORT_W-1:0] rdata_q;
  logic [PSEL_W-1:0] psel;

  assign psel = idx_i[IDX_W-1:1];

  gpio_sync #(.W(PAD_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pin_w)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_i && (psel == PSEL_W'(p));

    gpio_port #(.W(PORT_W)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_data_i(hit && (idx_i[0] == gpio_rf_pkg::REG_DATA)),
      .wr_dir_i (hit && (idx_i[0] == gpio_rf_pkg::REG_DIR)),
      .wdata_i  (wdata_i),
      .latch_o  (latch_w[p]),
      .dir_o    (dir_w[p])
    );

    // tristate control: value from latch, enable from direction
    assign pad_o[p*PORT_W +: PORT_W]    = latch_w[p];
    assign pad_oe_o[p*PORT_W +: PORT_W] = dir_w[p];
  end

  gpio_rdmux #(.N(NUM_PORTS), .W(PORT_W), .IDX_W(IDX_W)) u_rdmux (
    .idx_i  (idx_i),
    .pin_i  (pin_w),
    .dir_i  (dir_w),
    .rdata_o(rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  p_rd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  p_rd_dir_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_i[0]) |=> (rdata_o == $past(dir_w[psel])));
  p_rd_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !idx_i[0]) |=> (rdata_o == $past(pin_w[psel])));
endmodule

// File: tb/gpio_regfile_test.sv
`timescale 1ns/1ps
module gpio_regfile_test;
  localparam int N = 8;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] idx = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [N*W-1:0] pad_in, pad_out, pad_oe, ext;

  logic [W-1:0] m_lat [N];
  logic [W-1:0] m_dir [N];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // loopback pad: driven bits follow output, others follow external level
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out),
    .pad_oe_o(pad_oe)
  );

  function automatic logic [W-1:0] exp_read(input logic [3:0] i);
    int p = int'(i[3:1]);
    logic [W-1:0] e = ext[p*W +: W];
    if (i[0]) return m_dir[p];
    return (m_dir[p] & m_lat[p]) | (~m_dir[p] & e);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] i, input logic [W-1:0] d);
    @(negedge clk);
    idx = i; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (i[0]) m_dir[i[3:1]] = d; else m_lat[i[3:1]] = d;
  endtask

  task automatic rd_reg(input logic [3:0] i, output logic [W-1:0] d);
    @(negedge clk);
    idx = i; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic check_pads(input string req);
    logic [N*W-1:0] el = '0, ed = '0;
    for (int p = 0; p < N; p++) begin
      el[p*W +: W] = m_lat[p];
      ed[p*W +: W] = m_dir[p];
    end
    check({req, " pad_o"}, 64'(pad_out), 64'(el));
    check({req, " pad_oe_o"}, 64'(pad_oe), 64'(ed));
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r, held;
    void'($urandom(32'h5eed_1234));
    ext = '0;
    for (int p = 0; p < N; p++) begin m_lat[p] = '0; m_dir[p] = '0; end
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 oe", 64'(pad_oe), 64'h0);
    check("R1 out", 64'(pad_out), 64'h0);
    check("R1 rdata", 64'(rdata), 64'h0);

    // R3 R5 direction write and readback, port 3 -> index 7
    wr_reg(4'd7, 8'hA5);
    rd_reg(4'd7, r);
    check("R3 dir readback", 64'(r), 64'hA5);
    check("R5 oe slice", 64'(pad_oe[3*W +: W]), 64'hA5);

    // R4 data write, port 3 -> index 6
    wr_reg(4'd6, 8'h3C);
    check("R4 pad_o slice", 64'(pad_out[3*W +: W]), 64'h3C);

    // R2 R6 R7 mixed pin read
    ext[3*W +: W] = 8'h0F;
    idle(3);
    rd_reg(4'd6, r);
    check("R7 R6 mixed read", 64'(r), 64'(exp_read(4'd6)));

    // R6 latch not returned for input pins, port 0
    wr_reg(4'd0, 8'hFF);
    ext[0 +: W] = 8'h00;
    idle(3);
    rd_reg(4'd0, r);
    check("R6 input ignores latch", 64'(r), 64'h00);

    // R2 port 7 pin bits map to [63:56]
    ext[7*W +: W] = 8'h96;
    idle(3);
    rd_reg(4'd14, r);
    check("R2 port7 pins", 64'(r), 64'h96);

    // R7 all outputs on port 5
    wr_reg(4'd11, 8'hFF);
    wr_reg(4'd10, 8'h5A);
    ext[5*W +: W] = 8'hA5;
    idle(3);
    rd_reg(4'd10, r);
    check("R7 driven readback", 64'(r), 64'h5A);

    // R8 hold with rd low
    held = rdata;
    wr_reg(4'd11, 8'h00);
    ext = ~ext;
    idle(4);
    check("R8 hold", 64'(rdata), 64'(held));

    // R10 read and write same index in one cycle
    @(negedge clk);
    idx = 4'd7; wdata = 8'h11; wr = 1'b1; rd = 1'b1;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    check("R10 old value", 64'(rdata), 64'(m_dir[3]));
    m_dir[3] = 8'h11;
    rd_reg(4'd7, r);
    check("R10 new value", 64'(r), 64'h11);

    // R9 isolation after directed writes
    check_pads("R9");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [3:0] i = 4'($urandom_range(0, 15));
      case ($urandom_range(0, 2))
        0: wr_reg(i, 8'($urandom));
        1: ext = {$urandom, $urandom};
        default: ;
      endcase
      idle(3);
      rd_reg(i, r);
      check(i[0] ? "R3 rand dir" : "R6 rand pin", 64'(r), 64'(exp_read(i)));
      if (it % 50 == 0) check_pads("R9 R5 rand");
    end
    check_pads("R9 R4 final");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule